// File: doc/BRIEF.md
# Serial Transmit Channel with Selectable Bit Clock

This block sends bytes out on one serial data line, either as framed asynchronous characters or as a clocked synchronous bit stream. Software writes a byte into a holding register and then releases it with a read-then-write handshake on the status register. The byte moves into a shift register as soon as the shifter can take it. If another byte is already waiting when a character ends, it follows with no idle time on the line.

A two-bit clock-source field in the control register selects where bit timing comes from. One source is an internal rate strobe, which pulses once per half bit period. The other is an external clock on the serial-clock pin. The same field sets the pin direction and its role. The pin can be an ignored input, a free-running bit-rate clock output, a gated shift clock output, or an external clock input. In asynchronous mode that input runs at 16 times the bit rate. In synchronous mode it is the shift clock itself.

A transmit-end flag is set when a character completes and no new byte is waiting. Combined with an enable bit, this flag drives the interrupt line. The interrupt goes away either through the status handshake or by clearing the enable bit.

Top module: `stx_channel`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x03 (bit 0 = data-register-empty, bit 1 = transmit-end), `txd` is 1, `sck_oe` is 0 and `irq` is 0.
- R2: In asynchronous mode a character is a 0 start bit, eight data bits LSB first and a 1 stop bit. With the internal source each bit lasts two `rate_tick` pulses, and the line idles at 1.
- R3: In synchronous mode with the internal source, only the eight data bits are sent, LSB first. `sck_out` idles high, falls as each bit starts, rises once at mid-bit (eight rises per byte), and returns high after the byte.
- R4: Control bit 1 (external source) = 1 makes `sck_oe` 0. With bit 1 = 0 in synchronous mode (control bit 2 = 1), `sck_oe` is 1. With bit 1 = 0 in asynchronous mode, `sck_oe` equals control bit 0.
- R5: In asynchronous mode with the internal source and control bit 0 = 1, `sck_out` toggles on every `rate_tick`, so one clock period equals one bit.
- R6: In asynchronous mode with the external source, each bit lasts 16 rising edges of `sck_in`.
- R7: In synchronous mode with the external source, bit 0 is held on `txd` from the load until the first synchronized falling edge of `sck_in`. Each falling edge then ends the current bit, eight edges per byte, and nothing shifts without an edge.
- R8: Writing status bit 0 as 0 clears the empty flag only when the previous status access was a read that saw that flag at 1. Without such a read, the write has no effect.
- R9: The empty flag returns to 1 when the byte moves into the shifter. A byte released during a character starts right after its stop bit, with no idle bit in between.
- R10: The transmit-end flag is set when a character ends with no byte waiting, and `irq` = that flag AND control bit 3. An armed status write with bit 1 = 0 clears the flag.
- R11: Writing control bit 3 to 0 drops `irq` while the transmit-end flag stays set.
- R12: Control bit 0 has no effect on `sck_oe` in synchronous mode or when the external source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the status handshake) |
| reg_addr | input | 2 | 0 control, 1 data, 2 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| rate_tick | input | 1 | Internal rate strobe, one pulse per half bit |
| sck_in | input | 1 | Serial-clock pin input |
| sck_out | output | 1 | Serial-clock pin output value |
| sck_oe | output | 1 | Serial-clock pin output enable |
| txd | output | 1 | Serial data output |
| irq | output | 1 | Transmit-end interrupt |

## Verification
Bytes with different bit patterns (0xA5, 0x3C, 0x7E, 0x81, 0x96, 0x4D, 0x5A, 0xC2) are sent in each of the four clock configurations. A wrong bit order, a missing start or stop bit, or a wrong bit length therefore shows up as a miscompared byte. Two bytes are queued back to back so that the gap between one stop bit and the next start bit is measured, which separates correct pending-byte chaining from a return to idle. The external-clock cases hold `sck_in` still to show that nothing advances without an edge. The status handshake is also run without its read, which separates an armed clear from an unconditional one.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;
   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_DATA = 2'd1,
      RA_STAT = 2'd2
   } reg_addr_e;

   typedef struct packed {
      logic end_ie;     // bit 3: transmit-end interrupt enable
      logic sync_mode;  // bit 2: synchronous framing
      logic src_hi;     // bit 1: external clock source
      logic src_lo;     // bit 0: clock output in async internal mode
   } ctrl_t;

   localparam int CTRL_W     = $bits(ctrl_t);
   localparam int ST_EMPTY_B = 0;
   localparam int ST_DONE_B  = 1;
endpackage

// File: rtl/stx_regs.sv
`timescale 1ns/1ps
module stx_regs
   import stx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              take,
   input  logic              fin,
   output ctrl_t             ctrl,
   output logic [DATA_W-1:0] hold_data,
   output logic              pend,
   output logic              irq
);
   initial begin
      assert (DATA_W >= CTRL_W) else $error("stx_regs: DATA_W too small for control field");
   end

   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] data_q;
   logic              empty_q;
   logic              done_q;
   logic              arm_q;

   logic wr_ctrl, wr_data, wr_stat, rd_stat;
   assign wr_ctrl = wr && (addr == RA_CTRL);
   assign wr_data = wr && (addr == RA_DATA);
   assign wr_stat = wr && (addr == RA_STAT);
   assign rd_stat = rd && (addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_data) data_q <= wdata;
      end
   end

   // handshake arm: a status read that sees the empty flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q <= 1'b0;
      else if (wr_stat) arm_q <= 1'b0;
      else if (rd_stat && empty_q) arm_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         done_q  <= 1'b1;
      end else begin
         if (take)                                          empty_q <= 1'b1;
         else if (wr_stat && arm_q && !wdata[ST_EMPTY_B])   empty_q <= 1'b0;
         if (fin)                                           done_q  <= 1'b1;
         else if (wr_stat && arm_q && !wdata[ST_DONE_B])    done_q  <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
         RA_DATA: rdata = data_q;
         RA_STAT: begin
            rdata[ST_EMPTY_B] = empty_q;
            rdata[ST_DONE_B]  = done_q;
         end
         default: rdata = '0;
      endcase
   end

   assign ctrl      = ctrl_q;
   assign hold_data = data_q;
   assign pend      = !empty_q;
   assign irq       = ctrl_q.end_ie && done_q;

   // R8: empty flag only falls after an arming read
   p_armed_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(empty_q) |-> $past(arm_q));
   // R9: a byte taken by the shifter frees the holding register
   p_take_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> empty_q);
   // R10: character end with nothing waiting raises the end flag
   p_fin_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> done_q);
endmodule

// File: rtl/stx_clkgen.sv
`timescale 1ns/1ps
module stx_clkgen
   import stx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl,
   input  logic  busy,
   input  logic  rate_tick,
   input  logic  sck_in,
   output logic  adv,
   output logic  sck_out,
   output logic  sck_oe
);
   localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("stx_clkgen: need at least two sync stages");
      assert (OVS >= 2)         else $error("stx_clkgen: oversample factor below 2");
   end

   // external clock synchronizer and edge detect
   logic [SYNC_STAGES-1:0] sy_q;
   logic                   ext_prev_q;
   logic                   ext_lvl, ext_rise, ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sy_q       <= '1;
         ext_prev_q <= 1'b1;
      end else begin
         sy_q       <= {sy_q[SYNC_STAGES-2:0], sck_in};
         ext_prev_q <= ext_lvl;
      end
   end

   assign ext_lvl  = sy_q[SYNC_STAGES-1];
   assign ext_rise = ext_lvl && !ext_prev_q;
   assign ext_fall = !ext_lvl && ext_prev_q;

   // oversample divider on external rising edges
   logic [OVS_W-1:0] ovs_q;
   logic             ovs_wrap;
   assign ovs_wrap = (ovs_q == OVS_W'(OVS - 1));

   generate
      if ((OVS & (OVS - 1)) == 0) begin : g_ovs_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ovs_q <= '0;
            else if (ext_rise) ovs_q <= ovs_q + 1'b1;
         end
      end else begin : g_ovs_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ovs_q <= '0;
            else if (ext_rise) ovs_q <= ovs_wrap ? '0 : ovs_q + 1'b1;
         end
      end
   endgenerate

   // internal half-bit phase
   logic phase_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         phase_q <= 1'b0;
      else if (ctrl.sync_mode && !busy)   phase_q <= 1'b0;
      else if (rate_tick)                 phase_q <= !phase_q;
   end

   always_comb begin
      if (ctrl.src_hi) adv = ctrl.sync_mode ? ext_fall : (ext_rise && ovs_wrap);
      else             adv = rate_tick && phase_q;
   end

   always_comb begin
      if (ctrl.src_hi) begin
         sck_oe  = 1'b0;
         sck_out = 1'b1;
      end else if (ctrl.sync_mode) begin
         sck_oe  = 1'b1;
         sck_out = busy ? phase_q : 1'b1;
      end else begin
         sck_oe  = ctrl.src_lo;
         sck_out = phase_q;
      end
   end

   // R3: the internal shift clock rests high between bytes
   p_sync_rest_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.src_hi && ctrl.sync_mode && !busy) |-> sck_out);
endmodule

// File: rtl/stx_shift.sv
`timescale 1ns/1ps
module stx_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              adv,
   input  logic              pend,
   input  logic [DATA_W-1:0] pdata,
   output logic              busy,
   output logic              txd,
   output logic              take,
   output logic              fin
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   initial begin
      assert (DATA_W >= 4) else $error("stx_shift: DATA_W below 4");
   end

   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               busy_q;
   logic               last;

   assign last = (cnt_q == CNT_W'(1));

   always_comb begin
      if (busy_q) take = pend && adv && last;
      else        take = pend && (sync_mode || adv);
      fin = busy_q && adv && last && !pend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (take) begin
         busy_q <= 1'b1;
         if (sync_mode) begin
            sh_q  <= {2'b11, pdata};
            cnt_q <= CNT_W'(DATA_W);
         end else begin
            sh_q  <= {1'b1, pdata, 1'b0};
            cnt_q <= CNT_W'(FRAME_W);
         end
      end else if (busy_q && adv) begin
         sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
         cnt_q <= cnt_q - 1'b1;
         if (last) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign txd  = busy_q ? sh_q[0] : 1'b1;

   // R2: an asynchronous character opens with a low start bit
   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_q) && !sync_mode) |-> !txd);
   // R10: a finishing character leaves the shifter idle
   p_fin_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy_q);
endmodule

// File: rtl/stx_channel.sv
`timescale 1ns/1ps
module stx_channel
   import stx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rate_tick,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   output logic              txd,
   output logic              irq
);
   ctrl_t             ctrl;
   logic [DATA_W-1:0] hold_data;
   logic              pend, take, fin, busy, adv;

   stx_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .take(take), .fin(fin),
      .ctrl(ctrl), .hold_data(hold_data), .pend(pend), .irq(irq)
   );

   stx_clkgen #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .busy(busy), .rate_tick(rate_tick),
      .sck_in(sck_in), .adv(adv), .sck_out(sck_out), .sck_oe(sck_oe)
   );

   stx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sync_mode(ctrl.sync_mode), .adv(adv),
      .pend(pend), .pdata(hold_data), .busy(busy), .txd(txd),
      .take(take), .fin(fin)
   );

   // R4, R12: external source always leaves the pin as an input
   p_ext_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.src_hi |-> !sck_oe);
endmodule

// File: tb/sim_stx_channel.sv
`timescale 1ns/1ps
module sim_stx_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       rate_tick = 1'b0;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, txd, irq;

   stx_channel u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rate_tick(rate_tick),
      .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd), .irq(irq)
   );

   always #4 clk = ~clk;

   int tests = 0, fails = 0;
   int cyc = 0;
   logic [7:0] exp_q[$];
   int mon_mode = 3;      // 0 async, 1 sync internal, other: idle
   int bit_clks = 8;
   int gap_chk = 0;
   int stop_cyc = 0;
   int sync_rises = 0;
   int sck_mode = 0;      // 0 hold high, 1 free run, 2 manual
   logic sck_manual = 1'b1;

   always @(posedge clk) cyc <= cyc + 1;

   // rate strobe: one pulse every 4 clocks (half bit)
   int tick_cnt = 0;
   always @(negedge clk) begin
      tick_cnt  = (tick_cnt + 1) % 4;
      rate_tick = (tick_cnt == 3);
   end

   int ext_cnt = 0;
   always @(negedge clk) begin
      ext_cnt = ext_cnt + 1;
      if (sck_mode == 1)      sck_in = ext_cnt[1];
      else if (sck_mode == 2) sck_in = sck_manual;
      else                    sck_in = 1'b1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_empty();
      logic [7:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(2'd2, s);
         if (s[0]) break;
      end
   endtask

   // driver: release a byte through the handshake and push the expectation
   task automatic send(input logic [7:0] b);
      logic [7:0] s;
      wait_empty();
      wr(2'd1, b);
      rd(2'd2, s);
      exp_q.push_back(b);
      wr(2'd2, 8'h00);
   endtask

   task automatic drain(input int tail);
      for (int i = 0; i < 20000; i++) begin
         if (exp_q.size() == 0) break;
         @(negedge clk);
      end
      repeat (tail) @(negedge clk);
   endtask

   // monitor: rebuilds bytes from the line and compares against the queue
   initial begin
      logic       txd_prev = 1'b1;
      logic       sck_prev = 1'b1;
      logic [7:0] got = 8'h00;
      int         nsync = 0;
      forever begin
         @(negedge clk);
         if (mon_mode == 0 && txd_prev && !txd) begin
            if (gap_chk != 0)
               chk("R9 no idle gap between queued bytes", ((cyc - stop_cyc) <= bit_clks/2 + 1), 1);
            repeat (bit_clks/2) @(negedge clk);
            chk("R2 start bit", txd, 1'b0);
            for (int i = 0; i < 8; i++) begin
               repeat (bit_clks) @(negedge clk);
               got[i] = txd;
            end
            repeat (bit_clks) @(negedge clk);
            chk("R2 stop bit", txd, 1'b1);
            stop_cyc = cyc;
            if (exp_q.size() == 0) chk("R2 unexpected async byte", got, 8'hxx);
            else chk((bit_clks == 8) ? "R2 async byte" : "R6 async byte on external clock",
                     got, exp_q.pop_front());
         end else if (mon_mode == 1 && !sck_prev && sck_out && sck_oe) begin
            got[nsync] = txd;
            nsync++;
            sync_rises++;
            if (nsync == 8) begin
               nsync = 0;
               if (exp_q.size() == 0) chk("R3 unexpected sync byte", got, 8'hxx);
               else chk("R3 sync byte", got, exp_q.pop_front());
            end
         end
         txd_prev = txd;
         sck_prev = sck_out;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] v;
      int         tog;
      logic       prev;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 txd idle", txd, 1'b1);
      chk("R1 sck_oe", sck_oe, 1'b0);
      chk("R1 irq", irq, 1'b0);
      rd(2'd0, v); chk("R1 control reset", v, 8'h00);

      // unarmed status write must not clear anything
      wr(2'd2, 8'h00);
      rd(2'd2, v); chk("R8 unarmed write ignored / R1 status reset", v, 8'h03);
      wr(2'd2, 8'h03);   // consume the arm without clearing

      // async, internal clock, pin ignored input
      wr(2'd0, 8'h00);
      @(negedge clk); chk("R4 async internal pin input", sck_oe, 1'b0);
      mon_mode = 0; bit_clks = 8;
      send(8'hA5);
      wait_empty();
      gap_chk = 1;
      send(8'h3C);
      drain(20);
      gap_chk = 0;
      rd(2'd2, v); chk("R10 end flag after last byte", v[1], 1'b1);

      // interrupt and its two ways out
      wr(2'd0, 8'h08);
      @(negedge clk); chk("R10 irq raised", irq, 1'b1);
      rd(2'd2, v);
      wr(2'd2, 8'h01);
      @(negedge clk); chk("R10 irq cleared by handshake", irq, 1'b0);
      send(8'h7E);
      drain(20);
      chk("R10 irq after character end", irq, 1'b1);
      wr(2'd0, 8'h00);
      @(negedge clk); chk("R11 irq dropped by enable", irq, 1'b0);
      rd(2'd2, v); chk("R11 end flag kept", v[1], 1'b1);

      // async, internal clock, clock output
      wr(2'd0, 8'h01);
      @(negedge clk); chk("R4 async clock output enabled", sck_oe, 1'b1);
      tog = 0; prev = sck_out;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sck_out != prev) tog++;
         prev = sck_out;
      end
      chk("R5 clock toggles per tick", tog, 10);
      send(8'h81);
      drain(20);

      // sync, internal clock
      mon_mode = 3;
      wr(2'd0, 8'h04);
      @(negedge clk); chk("R4 sync internal output", sck_oe, 1'b1);
      wr(2'd0, 8'h05);
      @(negedge clk); chk("R12 low bit ignored in sync", sck_oe, 1'b1);
      chk("R3 idle clock high", sck_out, 1'b1);
      sync_rises = 0;
      mon_mode = 1;
      send(8'h96);
      send(8'h4D);
      drain(20);
      chk("R3 rises for two bytes", sync_rises, 16);
      chk("R3 clock high after bytes", sck_out, 1'b1);

      // async, external clock at 16x
      mon_mode = 3;
      sck_mode = 1;
      wr(2'd0, 8'h03);
      @(negedge clk); chk("R12 low bit ignored with external source", sck_oe, 1'b0);
      mon_mode = 0; bit_clks = 64;
      send(8'h5A);
      drain(80);

      // sync, external clock
      mon_mode = 3;
      sck_mode = 2; sck_manual = 1'b1;
      wr(2'd0, 8'h07);
      @(negedge clk); chk("R4 sync external input", sck_oe, 1'b0);
      send(8'hC2);
      repeat (20) @(negedge clk);
      chk("R7 bit 0 held without edges", txd, 1'b0);
      begin
         logic [7:0] g;
         for (int i = 0; i < 8; i++) begin
            repeat (8) @(negedge clk);
            g[i] = txd;
            sck_manual = 1'b0;
            repeat (8) @(negedge clk);
            sck_manual = 1'b1;
         end
         if (exp_q.size() == 0) chk("R7 sync external byte missing", 8'h00, 8'hC2);
         else chk("R7 sync external byte", g, exp_q.pop_front());
      end
      repeat (10) @(negedge clk);
      chk("R7 line idle after eight edges", txd, 1'b1);
      rd(2'd2, v); chk("R7 end flag after eight edges", v[1], 1'b1);

      summary();
      $finish;
   end
endmodule